// File: doc/BRIEF.md
# Compare-Driven Output Flag Generator

This block owns the single output flag of one timer channel. The channel's counter is outside the block and supplies its events as one-cycle pulses: a match against the first compare value, a match against the second compare value, a rollover, and an edge on the secondary input. It also supplies a level that is high while counting is active. A 3-bit mode input chooses one of eight ways these events move the flag.

A channel can hand control of its flag to another channel. With force enabled, the other channel's broadcast compare pulse takes the place of the local compare pulses. A channel set as master broadcasts its own compare pulses. The flag then passes through a polarity inverter and a debug force-low stage before it reaches the pin. A load strobe presets the flag to a programmed idle level, and the start of counting is expected to follow that load. The raw flag is also given out as a status bit.

Top module: `oflag_gen`

## Requirements
- R1: After reset the flag register is 0, the pin output is 0 (invert low, no debug force) and the broadcast output is 0.
- R2: Mode codes 1, 2 and 3 clear, set and toggle the flag on the clock edge that samples a compare pulse (either compare). Without a compare pulse the flag holds.
- R3: In mode code 4 the first toggle needs a first-compare pulse and the next needs a second-compare pulse, alternating after that. A pulse of the compare not expected is ignored. The expectation returns to the first compare when the mode code changes or on an idle load.
- R4: Mode code 5 sets the flag on a compare pulse and clears it on a secondary-edge pulse. Mode code 6 sets it on a compare pulse and clears it on a rollover pulse. In both, a set and a clear in the same cycle leave the flag at 1.
- R5: In mode code 0 the flag takes the value of the counter-active input one clock later.
- R6: In mode code 7 the flag toggles on every clock while counter-active is high, which gives a half-rate gated clock. It is 0 one clock after counter-active is low.
- R7: With force enabled, local compare pulses have no effect and the force input pulse acts as the compare event in every compare-driven mode. In mode code 4 each force pulse toggles.
- R8: The broadcast output is high in the same cycle as any local compare pulse while master is enabled, and 0 otherwise.
- R9: With invert high the pin is the complement of the flag; with invert low it equals the flag.
- R10: An idle-load pulse loads the idle level into the flag on the next edge and overrides every other event in that cycle.
- R11: While debug is active and the 2-bit debug action code is 2 or 3, the pin is 0. Codes 0 and 1 leave the pin unchanged.
- R12: The status output always equals the flag register, whatever the invert and debug settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_mode | input | 3 | Output mode code 0..7 |
| hit_a | input | 1 | First compare match pulse |
| hit_b | input | 1 | Second compare match pulse |
| cnt_active | input | 1 | Counter is counting |
| roll_pulse | input | 1 | Counter rollover pulse |
| sec_edge | input | 1 | Secondary input edge pulse |
| force_en | input | 1 | Take flag events from another channel |
| force_in | input | 1 | Compare pulse broadcast by another channel |
| master_en | input | 1 | Broadcast local compare pulses |
| invert | input | 1 | Invert flag at the pin |
| idle_level | input | 1 | Level loaded on idle load |
| idle_load | input | 1 | Load idle level into the flag |
| dbg_active | input | 1 | Debug state is active |
| dbg_action | input | 2 | Debug action code |
| pin_out | output | 1 | Pin-level output |
| flag_state | output | 1 | Flag register, 1 means high |
| cmp_bcast | output | 1 | Compare pulse broadcast |

## Verification
The hardest state to reach is a mode change in mode 4 while the alternation pointer expects the second compare. To get there, the bench fires a first-compare pulse, leaves mode 4 for one cycle, and then returns to mode 4 with another first-compare pulse in the same cycle as the return. Only a pointer that was reset lets that pulse toggle the flag. The same-cycle set and clear collisions in modes 5 and 6 are driven in the same way, with both pulses sampled by one edge.

// File: rtl/oflag_pkg.sv
package oflag_pkg;
   localparam int MODE_W = 3;
   localparam int DBG_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      OM_ACTIVE   = 3'd0,
      OM_CLEAR    = 3'd1,
      OM_SET      = 3'd2,
      OM_TOGGLE   = 3'd3,
      OM_ALT      = 3'd4,
      OM_SET_EDGE = 3'd5,
      OM_SET_ROLL = 3'd6,
      OM_GATE     = 3'd7
   } omode_e;
endpackage

// File: rtl/oflag_alt_tracker.sv
module oflag_alt_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic restart,
   input  logic preset,
   input  logic hit_a,
   input  logic hit_b,
   input  logic ext_evt,
   output logic fire
);
   logic ptr_q;
   logic ptr_eff;

   assign ptr_eff = restart ? 1'b0 : ptr_q;
   assign fire    = enable & (ext_evt | (ptr_eff ? hit_b : hit_a));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= 1'b0;
      else if (preset) ptr_q <= 1'b0;
      else if (fire)   ptr_q <= ~ptr_eff;
      else             ptr_q <= ptr_eff;
   end

   // R3: once the pointer expects the second compare, a lone first-compare pulse must not fire
   assert_alt_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !restart && ptr_q && hit_a && !hit_b && !ext_evt) |-> !fire);
endmodule

// File: rtl/oflag_state.sv
module oflag_state
   import oflag_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  omode_e mode,
   input  logic   cmp_evt,
   input  logic   alt_fire,
   input  logic   cnt_active,
   input  logic   roll_pulse,
   input  logic   sec_edge,
   input  logic   idle_load,
   input  logic   idle_level,
   output logic   flag_q
);
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      unique case (mode)
         OM_ACTIVE:   flag_d = cnt_active;
         OM_CLEAR:    if (cmp_evt) flag_d = 1'b0;
         OM_SET:      if (cmp_evt) flag_d = 1'b1;
         OM_TOGGLE:   if (cmp_evt) flag_d = ~flag_q;
         OM_ALT:      if (alt_fire) flag_d = ~flag_q;
         OM_SET_EDGE: if (cmp_evt) flag_d = 1'b1; else if (sec_edge) flag_d = 1'b0;
         OM_SET_ROLL: if (cmp_evt) flag_d = 1'b1; else if (roll_pulse) flag_d = 1'b0;
         OM_GATE:     flag_d = cnt_active & ~flag_q;
         default:     flag_d = flag_q;
      endcase
      if (idle_load) flag_d = idle_level;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == OM_SET_EDGE || mode == OM_SET_ROLL) && cmp_evt && !idle_load) |=> flag_q);
   assert_follow_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OM_ACTIVE && !idle_load) |=> (flag_q == $past(cnt_active)));
   assert_gate_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OM_GATE && !cnt_active && !idle_load) |=> !flag_q);
   assert_idle_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      idle_load |=> (flag_q == $past(idle_level)));
   assert_alt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OM_ALT && !alt_fire && !idle_load) |=> $stable(flag_q));
endmodule

// File: rtl/oflag_out_stage.sv
module oflag_out_stage #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flag,
   input  logic       invert,
   input  logic       dbg_active,
   input  logic [1:0] dbg_action,
   output logic       pin
);
   logic force_low;
   logic pin_c;

   assign force_low = dbg_active & dbg_action[1];
   assign pin_c     = force_low ? 1'b0 : (flag ^ invert);

   generate
      if (OUT_REG) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= pin_c;
         end
         assign pin = pin_q;
         assert_dbg_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
            force_low |=> !pin);
      end else begin : g_comb
         assign pin = pin_c;
      end
   endgenerate
endmodule

// File: rtl/oflag_gen.sv
module oflag_gen #(
   parameter int MODE_BITS = 3,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MODE_BITS-1:0] out_mode,
   input  logic                 hit_a,
   input  logic                 hit_b,
   input  logic                 cnt_active,
   input  logic                 roll_pulse,
   input  logic                 sec_edge,
   input  logic                 force_en,
   input  logic                 force_in,
   input  logic                 master_en,
   input  logic                 invert,
   input  logic                 idle_level,
   input  logic                 idle_load,
   input  logic                 dbg_active,
   input  logic [1:0]           dbg_action,
   output logic                 pin_out,
   output logic                 flag_state,
   output logic                 cmp_bcast
);
   import oflag_pkg::*;

   initial begin
      if (MODE_BITS != MODE_W)
         $error("oflag_gen: MODE_BITS must equal %0d", MODE_W);
   end

   omode_e mode;
   logic [MODE_BITS-1:0] mode_q;
   logic mode_chg;
   logic loc_a, loc_b, cmp_evt, alt_fire, flag_q;

   assign mode     = omode_e'(out_mode);
   assign mode_chg = (mode_q != out_mode);
   assign loc_a    = hit_a & ~force_en;
   assign loc_b    = hit_b & ~force_en;
   assign cmp_evt  = force_en ? force_in : (hit_a | hit_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= out_mode;
   end

   oflag_alt_tracker u_alt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (mode == OM_ALT),
      .restart (mode_chg),
      .preset  (idle_load),
      .hit_a   (loc_a),
      .hit_b   (loc_b),
      .ext_evt (force_en & force_in),
      .fire    (alt_fire)
   );

   oflag_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .cmp_evt    (cmp_evt),
      .alt_fire   (alt_fire),
      .cnt_active (cnt_active),
      .roll_pulse (roll_pulse),
      .sec_edge   (sec_edge),
      .idle_load  (idle_load),
      .idle_level (idle_level),
      .flag_q     (flag_q)
   );

   oflag_out_stage #(.OUT_REG(OUT_REG)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag       (flag_q),
      .invert     (invert),
      .dbg_active (dbg_active),
      .dbg_action (dbg_action),
      .pin        (pin_out)
   );

   assign flag_state = flag_q;
   assign cmp_bcast  = master_en & (hit_a | hit_b);

   // R7: with force enabled, a set-mode flag at 0 stays 0 without a force pulse
   assert_force_blocks_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (force_en && !force_in && !idle_load && out_mode == 3'd2 && !flag_state) |=> !flag_state);
   // R11: pin is low whenever debug forces it
   assert_dbg_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!OUT_REG && dbg_active && dbg_action[1]) |-> !pin_out);
   // R9: without debug force the pin tracks flag and polarity
   assert_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!OUT_REG && !dbg_active) |-> (pin_out == (flag_state ^ invert)));
endmodule

// File: tb/oflag_gen_tb.sv
module oflag_gen_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] out_mode = 3'd0;
   logic hit_a = 0, hit_b = 0, cnt_active = 0, roll_pulse = 0, sec_edge = 0;
   logic force_en = 0, force_in = 0, master_en = 0, invert = 0;
   logic idle_level = 0, idle_load = 0, dbg_active = 0;
   logic [1:0] dbg_action = 2'd0;
   logic pin_out, flag_state, cmp_bcast;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   oflag_gen u_dut (
      .clk(clk), .rst_n(rst_n), .out_mode(out_mode), .hit_a(hit_a), .hit_b(hit_b),
      .cnt_active(cnt_active), .roll_pulse(roll_pulse), .sec_edge(sec_edge),
      .force_en(force_en), .force_in(force_in), .master_en(master_en), .invert(invert),
      .idle_level(idle_level), .idle_load(idle_load), .dbg_active(dbg_active),
      .dbg_action(dbg_action), .pin_out(pin_out), .flag_state(flag_state),
      .cmp_bcast(cmp_bcast)
   );

   task automatic chk(string tag, logic got, logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic preset(logic [2:0] m, logic lvl);
      out_mode = m; idle_level = lvl; idle_load = 1; step(); idle_load = 0;
   endtask

   task automatic pulse(logic a, logic b);
      hit_a = a; hit_b = b; step(); hit_a = 0; hit_b = 0;
   endtask

   task automatic t_reset();
      chk("R1 flag", flag_state, 0);
      chk("R1 pin", pin_out, 0);
      chk("R1 bcast", cmp_bcast, 0);
   endtask

   task automatic t_basic();
      preset(3'd2, 0); step(); chk("R2 set hold", flag_state, 0);
      pulse(0, 1); chk("R2 set", flag_state, 1);
      out_mode = 3'd1; step(); chk("R2 clear hold", flag_state, 1);
      pulse(1, 0); chk("R2 clear", flag_state, 0);
      out_mode = 3'd3; pulse(1, 0); chk("R2 toggle1", flag_state, 1);
      pulse(0, 1); chk("R2 toggle2", flag_state, 0);
   endtask

   task automatic t_alt();
      preset(3'd4, 0);
      pulse(0, 1); chk("R3 ignore b first", flag_state, 0);
      pulse(1, 0); chk("R3 a toggles", flag_state, 1);
      pulse(1, 0); chk("R3 ignore a second", flag_state, 1);
      pulse(0, 1); chk("R3 b toggles", flag_state, 0);
      pulse(1, 0); chk("R3 a again", flag_state, 1);
      out_mode = 3'd3; step();
      out_mode = 3'd4; pulse(1, 0); chk("R3 restart on mode change", flag_state, 0);
   endtask

   task automatic t_setclr();
      preset(3'd5, 0);
      pulse(1, 0); chk("R4 m5 set", flag_state, 1);
      sec_edge = 1; step(); sec_edge = 0; chk("R4 m5 clear", flag_state, 0);
      sec_edge = 1; pulse(1, 0); sec_edge = 0; chk("R4 m5 set wins", flag_state, 1);
      out_mode = 3'd6; roll_pulse = 1; step(); roll_pulse = 0;
      chk("R4 m6 clear", flag_state, 0);
      roll_pulse = 1; pulse(0, 1); roll_pulse = 0; chk("R4 m6 set wins", flag_state, 1);
   endtask

   task automatic t_active();
      preset(3'd0, 1); chk("R10 load high", flag_state, 1);
      cnt_active = 0; step(); chk("R5 follow low", flag_state, 0);
      cnt_active = 1; step(); chk("R5 follow high", flag_state, 1);
      cnt_active = 0;
   endtask

   task automatic t_gate();
      preset(3'd7, 0);
      cnt_active = 1;
      step(); chk("R6 gate 1", flag_state, 1);
      step(); chk("R6 gate 0", flag_state, 0);
      step(); chk("R6 gate 1b", flag_state, 1);
      cnt_active = 0; step(); chk("R6 gate stop", flag_state, 0);
   endtask

   task automatic t_force();
      force_en = 1; preset(3'd2, 0);
      pulse(1, 1); chk("R7 local ignored", flag_state, 0);
      force_in = 1; step(); force_in = 0; chk("R7 force sets", flag_state, 1);
      preset(3'd4, 0);
      force_in = 1; step(); chk("R7 alt force 1", flag_state, 1);
      step(); force_in = 0; chk("R7 alt force 2", flag_state, 0);
      force_en = 0;
   endtask

   task automatic t_master();
      master_en = 1; hit_a = 1; #2 chk("R8 bcast on", cmp_bcast, 1);
      hit_a = 0; hit_b = 1; #2 chk("R8 bcast b", cmp_bcast, 1);
      master_en = 0; #2 chk("R8 bcast off", cmp_bcast, 0);
      hit_b = 0; step();
   endtask

   task automatic t_idle_invert();
      out_mode = 3'd2; idle_level = 0; idle_load = 1; hit_a = 1; step();
      idle_load = 0; hit_a = 0; chk("R10 load beats set", flag_state, 0);
      invert = 1; #2 chk("R9 inverted", pin_out, 1);
      chk("R12 status raw", flag_state, 0);
      invert = 0; #2 chk("R9 plain", pin_out, 0);
   endtask

   task automatic t_debug();
      preset(3'd2, 1);
      dbg_active = 1;
      for (int c = 0; c < 4; c++) begin
         dbg_action = c[1:0]; #2
         chk($sformatf("R11 dbg code %0d", c), pin_out, c < 2);
         chk("R12 status under dbg", flag_state, 1);
      end
      dbg_active = 0; dbg_action = 0; step();
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      step(); step();
      t_reset();
      rst_n = 1; step();
      t_basic();
      t_alt();
      t_setclr();
      t_active();
      t_gate();
      t_force();
      t_master();
      t_idle_invert();
      t_debug();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule